// File: doc/BRIEF.md
# Receive Parser Instruction Table Access Controller

This block is the register front end of a receive frame parser. The parser keeps its instruction table in an internal RAM that the 32-bit register port cannot address directly. Software reaches the table through a data register and an access control register. It loads the data word, writes the word address and the direction, and then sets a start bit. That bit reads back as busy until the access has finished. A write commits the data word to the table. A read loads the addressed table word into the data register.

The block also holds the parser enable bit and the counts of valid and parsable entries that software programs once the table is filled. It reports through an idle flag when the parser has come to rest. The frame matching engine is not part of this block. A delay stub stands in for it: the idle flag clears a fixed number of cycles after the parser is enabled, and sets again a fixed number of cycles after it is disabled. Register reads are combinational on the address.

Top module: `rxp_table_regs`

## Requirements
- R1: After reset the parser is disabled, the idle flag is 1, both counts are 0, busy is 0, and the data register is 0.
- R2: Bit 15 of the mode register at offset 0xC00 is the parser enable and can be read and written. All other bits of that register read 0.
- R3: At offset 0xCA0, bits 7:0 (valid count) and bits 23:16 (parsable count) can be read and written. Bit 31 reads the idle flag. All other bits read 0.
- R4: The idle flag clears WAKE_DLY cycles after the enable bit is written to 1. It sets STOP_DLY cycles after the enable bit is written to 0. A write to bit 31 of 0xCA0 has no effect on it.
- R5: The access control register at 0xCB0 stores the word address in bits 15:0, the direction in bit 16 (1 = write, 0 = read) and the error-injection fields in bits 22:20, and reads them back. Bits 30:23 and 19:17 read 0.
- R6: Writing 0xCB0 with bit 31 set while busy is 0 launches one access. Bit 31 then reads 1 for exactly ACC_LAT cycles and returns to 0.
- R7: A write access stores the data register (offset 0xCB4) into the table word at the given address.
- R8: A read access loads the addressed table word into the data register.
- R9: Each entry occupies WORDS consecutive words at word address entry*WORDS+offset, and every word is stored independently.
- R10: An access to a word address at or above ENTRIES*WORDS completes normally. It leaves the table unchanged, and for a read it leaves the data register unchanged.
- R11: While busy is 1, writes to 0xCB0 and 0xCB4 are ignored.
- R12: A write to 0xCB0 with bit 31 clear updates the fields but launches no access.
- R13: Offsets other than the four registers read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The table is filled with word addresses that step through every offset of three adjacent entries, each word holding a different value. Reading them all back shows up address aliasing and a wrong entry stride. An address one past the last word, accesses issued while busy, and control writes with the start bit clear each check that nothing changes when it should not, against the accesses that do change the table. The enable bit is toggled both with a full wait and in quick succession, which separates correct wake and stop delays from counters that are off by one or never restart.

// File: rtl/rxp_table_regs.sv
module rxp_table_regs #(
  parameter int ENTRIES  = 64,
  parameter int WORDS    = 4,
  parameter int ACC_LAT  = 3,
  parameter int WAKE_DLY = 2,
  parameter int STOP_DLY = 6,
  parameter int AW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  localparam int DEPTH = ENTRIES * WORDS;
  localparam int TW    = $clog2(DEPTH);
  localparam int LCW   = $clog2(ACC_LAT + 1);
  localparam int DMAX  = (WAKE_DLY > STOP_DLY) ? WAKE_DLY : STOP_DLY;
  localparam int DCW   = $clog2(DMAX + 1);
  localparam logic [AW-1:0] OFF_MODE = AW'('hC00);
  localparam logic [AW-1:0] OFF_CTRL = AW'('hCA0);
  localparam logic [AW-1:0] OFF_IACC = AW'('hCB0);
  localparam logic [AW-1:0] OFF_DATA = AW'('hCB4);

  logic           en_q, idle_q;
  logic [DCW-1:0] pcnt;
  logic [7:0]     nve_q, npe_q;
  logic [15:0]    ia_addr;
  logic           ia_wr;
  logic [2:0]     ia_err;
  logic           busy;
  logic [LCW-1:0] bcnt;
  logic [31:0]    data_q;
  logic [31:0]    mem [DEPTH];

  wire wr_mode = wr_en && addr == OFF_MODE;
  wire wr_ctrl = wr_en && addr == OFF_CTRL;
  wire wr_iacc = wr_en && addr == OFF_IACC && !busy;
  wire wr_data = wr_en && addr == OFF_DATA && !busy;
  wire done    = busy && bcnt == LCW'(ACC_LAT - 1);
  wire in_rng  = 32'(ia_addr) < DEPTH;
  wire [TW-1:0] idx = ia_addr[TW-1:0];
  wire pending = en_q == idle_q;
  wire [DCW-1:0] tgt = en_q ? DCW'(WAKE_DLY - 1) : DCW'(STOP_DLY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      nve_q <= '0;
      npe_q <= '0;
    end else begin
      if (wr_mode) en_q <= wdata[15];
      if (wr_ctrl) begin
        nve_q <= wdata[7:0];
        npe_q <= wdata[23:16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      pcnt   <= '0;
    end else if (pending) begin
      if (pcnt == tgt) begin
        idle_q <= ~idle_q;
        pcnt   <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end else begin
      pcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ia_addr <= '0;
      ia_wr   <= 1'b0;
      ia_err  <= '0;
      busy    <= 1'b0;
      bcnt    <= '0;
    end else if (wr_iacc) begin
      ia_addr <= wdata[15:0];
      ia_wr   <= wdata[16];
      ia_err  <= wdata[22:20];
      busy    <= wdata[31];
      bcnt    <= '0;
    end else if (done) begin
      busy <= 1'b0;
      bcnt <= '0;
    end else if (busy) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        data_q <= '0;
    else if (wr_data)                  data_q <= wdata;
    else if (done && !ia_wr && in_rng) data_q <= mem[idx];
  end

  always_ff @(posedge clk)
    if (done && ia_wr && in_rng) mem[idx] <= data_q;

  always_comb begin
    case (addr)
      OFF_MODE: rdata = {16'b0, en_q, 15'b0};
      OFF_CTRL: rdata = {idle_q, 7'b0, npe_q, 8'b0, nve_q};
      OFF_IACC: rdata = {busy, 8'b0, ia_err, 3'b0, ia_wr, ia_addr};
      OFF_DATA: rdata = data_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxp_table_regs_chk.sv
module rxp_table_regs_chk #(
  parameter int ACC_LAT = 3,
  parameter int AW      = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          en,
  input logic          idle,
  input logic          busy,
  input logic [15:0]   ia_addr,
  input logic          ia_wr
);
  logic [31:0] bc;
  always_ff @(posedge clk)
    if (!rst_n) bc <= '0;
    else        bc <= busy ? bc + 1 : '0;

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bc < ACC_LAT); // R6
  AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bc == ACC_LAT); // R6
  AST_LAUNCH_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == AW'('hCB0) && wdata[31])); // R6
  AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ia_addr) && $stable(ia_wr)); // R11
  AST_IDLE_RISE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> !en); // R4
  AST_IDLE_FALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> en); // R4
endmodule

bind rxp_table_regs rxp_table_regs_chk #(.ACC_LAT(ACC_LAT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en(en_q), .idle(idle_q), .busy(busy), .ia_addr(ia_addr), .ia_wr(ia_wr)
);

// File: tb/rxp_table_regs_bench.sv
module rxp_table_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 64, WORDS = 4, LAT = 3, WAKE = 2, STOP = 6;
  localparam int DEPTH = ENTRIES * WORDS;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  int m_en, m_idle, m_pcnt, m_nve, m_npe, m_ia_addr, m_ia_wr, m_err, m_busy, m_bcnt;
  logic [31:0] m_data;
  logic [31:0] m_mem [int];

  rxp_table_regs #(.ENTRIES(ENTRIES), .WORDS(WORDS), .ACC_LAT(LAT),
                   .WAKE_DLY(WAKE), .STOP_DLY(STOP), .AW(12)) u_rxp_table_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'hC00: return m_en ? 32'h8000 : 32'h0;
      12'hCA0: return {m_idle[0], 7'b0, m_npe[7:0], 8'b0, m_nve[7:0]};
      12'hCB0: return {m_busy[0], 8'b0, m_err[2:0], 3'b0, m_ia_wr[0], m_ia_addr[15:0]};
      12'hCB4: return m_data;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_en = 0; m_idle = 1; m_pcnt = 0; m_nve = 0; m_npe = 0;
    m_ia_addr = 0; m_ia_wr = 0; m_err = 0; m_busy = 0; m_bcnt = 0; m_data = 0;
  endtask

  task automatic model_step(input logic w, input logic [11:0] a, input logic [31:0] d);
    int old_busy = m_busy;
    int old_en = m_en;
    if (old_en == m_idle) begin
      m_pcnt++;
      if (m_pcnt == (old_en ? WAKE : STOP)) begin m_idle = !m_idle; m_pcnt = 0; end
    end else m_pcnt = 0;
    if (old_busy) begin
      m_bcnt++;
      if (m_bcnt == LAT) begin
        m_busy = 0;
        if (m_ia_addr < DEPTH) begin
          if (m_ia_wr) m_mem[m_ia_addr] = m_data;
          else if (m_mem.exists(m_ia_addr)) m_data = m_mem[m_ia_addr];
        end
      end
    end
    if (w) begin
      if (a == 12'hC00) m_en = d[15];
      if (a == 12'hCA0) begin m_nve = d[7:0]; m_npe = d[23:16]; end
      if (a == 12'hCB0 && !old_busy) begin
        m_ia_addr = d[15:0]; m_ia_wr = d[16]; m_err = d[22:20];
        m_busy = d[31]; m_bcnt = 0;
      end
      if (a == 12'hCB4 && !old_busy) m_data = d;
    end
  endtask

  task automatic tick(input logic w, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] exp;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    #1;
    exp = model_read(a);
    checks++;
    if (rdata !== exp) begin
      failures++;
      $display("FAIL %s offset %h actual %h expected %h", cur_req, a, rdata, exp);
    end
    @(posedge clk);
    if (rst_n) model_step(w, a, d);
    cycles++;
  endtask

  task automatic look(input logic [11:0] a, input int n);
    for (int i = 0; i < n; i++) tick(0, a, 0);
  endtask

  task automatic access(input int waddr, input logic wr, input logic [31:0] d, input logic [2:0] err);
    logic [31:0] c = {8'b0, err, 3'b0, 1'b0, waddr[15:0]};
    if (wr) tick(1, 12'hCB4, d);
    tick(1, 12'hCB0, c);
    tick(1, 12'hCB0, c | (wr ? 32'h1_0000 : 0));
    tick(1, 12'hCB0, c | (wr ? 32'h1_0000 : 0) | 32'h8000_0000);
    look(12'hCB0, LAT + 1);
  endtask

  initial begin
    model_reset();
    tick(0, 12'hC00, 0);
    tick(0, 12'hC00, 0);
    rst_n = 1;
    cur_req = "R1";
    look(12'hC00, 1); look(12'hCA0, 1); look(12'hCB0, 1); look(12'hCB4, 1);
    cur_req = "R2";
    tick(1, 12'hC00, 32'hFFFF_FFFF);
    cur_req = "R4";
    look(12'hCA0, WAKE + 2);
    tick(1, 12'hC00, 0);
    look(12'hCA0, STOP + 2);
    tick(1, 12'hC00, 32'h8000);
    tick(1, 12'hC00, 0);
    tick(1, 12'hC00, 32'h8000);
    look(12'hCA0, WAKE + 2);
    tick(1, 12'hC00, 0);
    look(12'hCA0, 2);
    tick(1, 12'hC00, 32'h8000);
    look(12'hCA0, 3);
    tick(1, 12'hC00, 0);
    look(12'hCA0, STOP + 1);
    cur_req = "R3";
    tick(1, 12'hCA0, 32'h7FAB_CD12);
    look(12'hCA0, 2);
    tick(1, 12'hCA0, 32'h8004_0003);
    look(12'hCA0, 1);
    cur_req = "R5";
    tick(1, 12'hCB0, 32'h7FFF_FFFF);
    look(12'hCB0, 2);
    cur_req = "R12";
    tick(1, 12'hCB0, 32'h0051_0007);
    look(12'hCB0, 3);
    cur_req = "R7";
    for (int e = 0; e < 3; e++)
      for (int w = 0; w < WORDS; w++)
        access(e * WORDS + w, 1, 32'hA500_0000 + e * 256 + w * 17, 3'(e + w));
    cur_req = "R8";
    for (int e = 2; e >= 0; e--)
      for (int w = 0; w < WORDS; w++) begin
        cur_req = (e == 1) ? "R9" : "R8";
        access(e * WORDS + w, 0, 0, 3'b0);
        look(12'hCB4, 1);
      end
    cur_req = "R9";
    access(DEPTH - 1, 1, 32'h1234_5678, 3'b101);
    access(DEPTH - 1, 0, 0, 3'b0);
    look(12'hCB4, 1);
    cur_req = "R10";
    access(DEPTH, 1, 32'hDEAD_BEEF, 3'b0);
    access(0, 0, 0, 3'b0);
    look(12'hCB4, 1);
    access(DEPTH, 0, 0, 3'b0);
    look(12'hCB4, 1);
    access(16'hFFFF, 0, 0, 3'b0);
    look(12'hCB4, 1);
    cur_req = "R11";
    tick(1, 12'hCB4, 32'h0BAD_F00D);
    tick(1, 12'hCB0, 32'h8001_0005);
    tick(1, 12'hCB4, 32'h1111_2222);
    tick(1, 12'hCB0, 32'h8001_0009);
    tick(1, 12'hCB0, 32'h0000_0002);
    look(12'hCB0, LAT);
    access(5, 0, 0, 3'b0);
    look(12'hCB4, 1);
    access(9, 0, 0, 3'b0);
    look(12'hCB4, 1);
    cur_req = "R13";
    tick(1, 12'hC04, 32'hFFFF_FFFF);
    look(12'hC04, 1);
    tick(1, 12'hCB8, 32'hFFFF_FFFF);
    look(12'hCB8, 1); look(12'hC00, 1); look(12'hCA0, 1); look(12'hCB0, 1); look(12'hCB4, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual %0d cycles expected completion", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule